// File: doc/BRIEF.md
# Adaptive dead-time half-bridge controller

This block converts a single PWM command into two gate commands, one for the high-side (top) switch and one for the low-side (bottom) switch of a half-bridge, and guarantees the two are never on together. The bottom switch is released adaptively: it turns on only when the top command is already off and a comparator flag reports that the phase node has fallen near ground. The top switch is released by a timer: the bottom command must have been off for a fixed base count plus a programmable extension.

Around that interlock sit a set of overrides, in strict priority. Disable or supply undervoltage turns everything off and drops power-ready. Over-temperature turns both gates off. Over-voltage forces the bottom switch on and the top switch off, so the output capacitors can discharge through the inductor. A low synchronous-mode select holds the bottom switch off (diode-emulation operation). A mirror output repeats the bottom command while synchronous mode is selected. All flags are asynchronous to the clock and pass through a two-flop synchronizer. Outputs are registered.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it, all four outputs are low.
- R2: Each input reaches the outputs through two synchronizer flops and one output register: a change driven between edges shows at the outputs after the third following rising edge.
- R3: The top and bottom gate commands are never high in the same cycle.
- R4: In synchronous mode with the PWM command low, the bottom command rises only if the top command was low in the cycle before and the synchronized phase-low flag is high; once on, it stays on while PWM stays low, whatever the phase flag does.
- R5: In normal or asynchronous mode the top command rises with PWM high only once the bottom command has been low for more than BASE_DT_CYC + dt_ext_in consecutive cycles.
- R6: The dead-time count restarts from zero when the synchronized PWM toggles before the count has reached its limit; a toggle after the limit leaves it expired.
- R7: With the synchronous-mode select low and no fault, the bottom command stays low and the top command follows PWM under R5.
- R8: The mirror output equals the bottom command when the synchronous-mode select was high at that edge, and is low otherwise (also during an over-voltage discharge).
- R9: With enable low or supply-good low, top, bottom and power-ready are low; power-ready is high exactly when both enable and supply-good are high.
- R10: Over-temperature drives both gate commands low, and takes precedence over over-voltage.
- R11: Over-voltage (without over-temperature) drives top low and bottom high, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | PWM command, high requests the top switch |
| en_in | input | 1 | Enable, low puts the block in standby |
| sync_mode_in | input | 1 | High selects synchronous operation, low holds the bottom switch off |
| supply_ok_in | input | 1 | Supply above the lockout threshold |
| ovp_in | input | 1 | Output over-voltage trip |
| otp_in | input | 1 | Over-temperature trip |
| phase_low_in | input | 1 | Phase node below the low threshold |
| dt_ext_in | input | DT_EXT_W | Dead-time extension in cycles, added to the base |
| top_gate_o | output | 1 | High-side gate command |
| bot_gate_o | output | 1 | Low-side gate command |
| pwr_rdy_o | output | 1 | Power-ready status |
| bot_dup_o | output | 1 | Mirror of the bottom command in synchronous mode |

## Verification
The bench builds the block with BASE_DT_CYC = 3 and DT_EXT_W = 3, so the whole extension range of 0 to 7 and the saturation of the dead-time counter are reached within a few cycles of each PWM edge. With windows that short, fast PWM bursts regularly toggle before the limit expires, exercising the restart, and rare fault pulses land in every phase of the interlock, including mid dead time and during a held-on bottom switch.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef struct packed {
    logic pwm;
    logic en;
    logic sync_mode;
    logic supply_ok;
    logic ovp;
    logic otp;
    logic phase_low;
  } hb_flags_t;

  localparam int HB_FLAG_W = $bits(hb_flags_t);

  // Override ladder, highest priority first
  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_OTP,
    MODE_OVP,
    MODE_ASYNC,
    MODE_SYNC
  } hb_mode_e;

endpackage

// File: rtl/hb_sync_bank.sv
module hb_sync_bank #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int BASE_DT_CYC = 1,
  parameter int DT_EXT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bot_on,
  input  logic                restart,
  input  logic [DT_EXT_W-1:0] ext,
  output logic                done
);

  localparam int MAX_DT = BASE_DT_CYC + (1 << DT_EXT_W) - 1;
  localparam int CNT_W  = $clog2(MAX_DT + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;
  localparam logic [CNT_W-1:0] BASE_V  = CNT_W'(BASE_DT_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = BASE_V + CNT_W'(ext);
  assign done  = (cnt >= limit);

  // Counts cycles with the bottom switch off; saturates so done holds
  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (bot_on)           cnt <= '0;
    else if (restart && !done) cnt <= '0;
    else if (cnt != CNT_SAT)   cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/hb_gate_core.sv
module hb_gate_core
  import hb_pkg::*;
#(
  parameter int BASE_DT_CYC = 1,
  parameter int DT_EXT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  hb_flags_t           f,
  input  logic [DT_EXT_W-1:0] dt_ext,
  output logic                top_o,
  output logic                bot_o,
  output logic                pr_o,
  output logic                dup_o
);

  hb_mode_e mode;
  logic     pwm_d;
  logic     pwm_edge;
  logic     dt_done;
  logic     top_q, bot_q, pr_q, dup_q;
  logic     top_n, bot_n;

  always_comb begin
    if (!(f.en && f.supply_ok)) mode = MODE_OFF;
    else if (f.otp)             mode = MODE_OTP;
    else if (f.ovp)             mode = MODE_OVP;
    else if (!f.sync_mode)      mode = MODE_ASYNC;
    else                        mode = MODE_SYNC;
  end

  assign pwm_edge = f.pwm ^ pwm_d;

  hb_dt_timer #(
    .BASE_DT_CYC (BASE_DT_CYC),
    .DT_EXT_W    (DT_EXT_W)
  ) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .bot_on  (bot_q),
    .restart (pwm_edge),
    .ext     (dt_ext),
    .done    (dt_done)
  );

  always_comb begin
    top_n = 1'b0;
    bot_n = 1'b0;
    unique case (mode)
      MODE_OFF, MODE_OTP: begin
        top_n = 1'b0;
        bot_n = 1'b0;
      end
      MODE_OVP: begin
        top_n = 1'b0;
        bot_n = 1'b1;
      end
      MODE_ASYNC: begin
        top_n = f.pwm && !bot_q && dt_done;
        bot_n = 1'b0;
      end
      MODE_SYNC: begin
        top_n = f.pwm && !bot_q && dt_done;
        bot_n = !f.pwm && !top_q && (bot_q || f.phase_low);
      end
      default: begin
        top_n = 1'b0;
        bot_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= 1'b0;
      bot_q <= 1'b0;
      pr_q  <= 1'b0;
      dup_q <= 1'b0;
      pwm_d <= 1'b0;
    end else begin
      top_q <= top_n;
      bot_q <= bot_n;
      pr_q  <= (mode != MODE_OFF);
      dup_q <= bot_n && f.sync_mode;
      pwm_d <= f.pwm;
    end
  end

  assign top_o = top_q;
  assign bot_o = bot_q;
  assign pr_o  = pr_q;
  assign dup_o = dup_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(top_q && bot_q)); // R3

  AST_BOT_AFTER_TOP: assert property (@(posedge clk) disable iff (rst)
    ($rose(bot_q) && $past(mode == MODE_SYNC)) |-> !$past(top_q)); // R4

  AST_TOP_AFTER_BOT: assert property (@(posedge clk) disable iff (rst)
    $rose(top_q) |-> (!$past(bot_q) && !bot_q)); // R5

  AST_DUP_MIRROR: assert property (@(posedge clk) disable iff (rst)
    f.sync_mode |=> (dup_q == bot_q)); // R8

  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (rst)
    !(f.en && f.supply_ok) |=> (!top_q && !bot_q && !pr_q)); // R9

  AST_OTP_OFF: assert property (@(posedge clk) disable iff (rst)
    (f.en && f.supply_ok && f.otp) |=> (!top_q && !bot_q)); // R10

  AST_OVP_DISCHARGE: assert property (@(posedge clk) disable iff (rst)
    (f.en && f.supply_ok && !f.otp && f.ovp) |=> (!top_q && bot_q)); // R11

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_DT_CYC = 1,
  parameter int DT_EXT_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pwm_in,
  input  logic                en_in,
  input  logic                sync_mode_in,
  input  logic                supply_ok_in,
  input  logic                ovp_in,
  input  logic                otp_in,
  input  logic                phase_low_in,
  input  logic [DT_EXT_W-1:0] dt_ext_in,
  output logic                top_gate_o,
  output logic                bot_gate_o,
  output logic                pwr_rdy_o,
  output logic                bot_dup_o
);

  hb_flags_t            raw_flags;
  hb_flags_t            syn_flags;
  logic [HB_FLAG_W-1:0] syn_vec;

  always_comb begin
    raw_flags.pwm       = pwm_in;
    raw_flags.en        = en_in;
    raw_flags.sync_mode = sync_mode_in;
    raw_flags.supply_ok = supply_ok_in;
    raw_flags.ovp       = ovp_in;
    raw_flags.otp       = otp_in;
    raw_flags.phase_low = phase_low_in;
  end

  hb_sync_bank #(
    .W      (HB_FLAG_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_flags),
    .q   (syn_vec)
  );

  assign syn_flags = hb_flags_t'(syn_vec);

  hb_gate_core #(
    .BASE_DT_CYC (BASE_DT_CYC),
    .DT_EXT_W    (DT_EXT_W)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .f      (syn_flags),
    .dt_ext (dt_ext_in),
    .top_o  (top_gate_o),
    .bot_o  (bot_gate_o),
    .pr_o   (pwr_rdy_o),
    .dup_o  (bot_dup_o)
  );

endmodule

// File: tb/hb_deadtime_ctrl_bench.sv
`timescale 1ns/1ps
module hb_deadtime_ctrl_bench;

  localparam int BASE = 3;
  localparam int EW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0, en = 1'b0, sm = 1'b0, ok = 1'b0;
  logic ovp = 1'b0, otp = 1'b0, ph = 1'b0;
  logic [EW-1:0] ext = '0;
  logic top, bot, pr, dup;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  hb_deadtime_ctrl #(
    .SYNC_STAGES (2),
    .BASE_DT_CYC (BASE),
    .DT_EXT_W    (EW)
  ) u_hb_deadtime_ctrl (
    .clk          (clk),
    .rst          (rst),
    .pwm_in       (pwm),
    .en_in        (en),
    .sync_mode_in (sm),
    .supply_ok_in (ok),
    .ovp_in       (ovp),
    .otp_in       (otp),
    .phase_low_in (ph),
    .dt_ext_in    (ext),
    .top_gate_o   (top),
    .bot_gate_o   (bot),
    .pwr_rdy_o    (pr),
    .bot_dup_o    (dup)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // bit order of a flag word: 6 pwm, 5 en, 4 sync, 3 ok, 2 ovp, 1 otp, 0 phase
  function automatic logic [1:0] gate_fn(input logic [6:0] s, input logic t, input logic b,
                                         input bit expired);
    logic nt, nb;
    if (!(s[5] && s[3])) return 2'b00; // R9
    if (s[1])            return 2'b00; // R10
    if (s[2])            return 2'b01; // R11
    nt = s[6] && !b && expired;                     // R5
    nb = s[4] && !s[6] && !t && (b || s[0]);        // R4, R7
    return {nt, nb};
  endfunction

  function automatic string tag_fn(input logic [6:0] s);
    if (!(s[5] && s[3])) return "R9";
    if (s[1])            return "R10";
    if (s[2])            return "R11";
    if (!s[4])           return "R7";
    return "R4";
  endfunction

  // Reference model
  logic [6:0] m_s1, m_s2;
  logic       m_pwm_prev, m_top, m_bot, m_pr, m_dup;
  int         m_age;
  string      m_tag = "R1";
  logic [1:0] m_g;
  bit         m_exp;
  int         m_lim;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_pwm_prev <= 1'b0;
      m_top <= 1'b0; m_bot <= 1'b0; m_pr <= 1'b0; m_dup <= 1'b0;
      m_age <= 0; m_tag <= "R1";
    end else begin
      m_lim = BASE + int'(ext);
      m_exp = (m_age >= m_lim);
      m_g   = gate_fn(m_s2, m_top, m_bot, m_exp);
      if (m_bot)                                   m_age <= 0;
      else if ((m_s2[6] != m_pwm_prev) && !m_exp)  m_age <= 0;   // R6
      else if (m_age < 100000)                     m_age <= m_age + 1;
      m_top      <= m_g[1];
      m_bot      <= m_g[0];
      m_dup      <= m_g[0] && m_s2[4];
      m_pr       <= m_s2[5] && m_s2[3];
      m_pwm_prev <= m_s2[6];
      m_tag      <= tag_fn(m_s2);
      m_s1       <= {pwm, en, sm, ok, ovp, otp, ph};
      m_s2       <= m_s1;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk(m_tag, int'({top, bot}), int'({m_top, m_bot}));
      chk("R8", int'(dup), int'(m_dup));
      chk("R9", int'(pr), int'(m_pr));
      chk("R3", int'(top && bot), 0);
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int a, b;
    bit saw;
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    chk("R1", int'({top, bot, pr, dup}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'({top, bot, pr, dup}), 0);
    chk_on = 1'b1;

    // R2: three-edge latency on power-ready
    en = 1'b1; ok = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2", int'(pr), 0);
    @(negedge clk);
    chk("R2", int'(pr), 1);

    // R4: bottom waits for phase-low
    sm = 1'b1; ph = 1'b0; ext = EW'(5); pwm = 1'b0;
    repeat (10) @(negedge clk);
    chk("R4", int'(bot), 0);
    ph = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4", int'(bot), 1);
    ph = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4", int'(bot), 1);
    ph = 1'b1;

    // R5: measured dead time from bottom off to top on
    pwm = 1'b1; a = -1; b = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (a < 0 && !bot) a = i;
      if (b < 0 && top)  b = i;
    end
    chk("R5", b - a, BASE + 5 + 1);

    // back to bottom on, then a fast burst without phase-low
    pwm = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4", int'(bot), 1);
    ph = 1'b0; saw = 1'b0;
    for (int k = 0; k < 10; k++) begin
      pwm = ~pwm;
      repeat (4) begin
        @(negedge clk);
        if (top) saw = 1'b1;
      end
    end
    chk("R6", int'(saw), 0);
    pwm = 1'b1;
    repeat (14) @(negedge clk);
    chk("R6", int'(top), 1);

    // R7: asynchronous mode
    sm = 1'b0; pwm = 1'b0; ph = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7", int'(bot), 0);
    chk("R8", int'(dup), 0);
    pwm = 1'b1;
    repeat (16) @(negedge clk);
    chk("R7", int'(top), 1);

    // R11: over-voltage discharge, in async then sync mode
    ovp = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", int'({top, bot}), 1);
    chk("R8", int'(dup), 0);
    sm = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", int'(dup), 1);

    // R10: over-temperature beats over-voltage
    otp = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", int'({top, bot}), 0);

    // R9: standby and lockout
    otp = 1'b0; ovp = 1'b0; en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", int'({top, bot, pr}), 0);
    en = 1'b1; ok = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", int'(pr), 0);
    ok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", int'(pr), 1);

    // Constrained random phase, checked every cycle against the model
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom_range(5) == 0) pwm = ~pwm;
      if ($urandom_range(3) == 0) ph = 1'($urandom_range(1));
      if ($urandom_range(199) == 0) sm = ~sm;
      if (en) en = ($urandom_range(499) != 0); else en = ($urandom_range(19) == 0);
      if (ok) ok = ($urandom_range(499) != 0); else ok = ($urandom_range(19) == 0);
      if (ovp) ovp = ($urandom_range(29) != 0); else ovp = ($urandom_range(399) == 0);
      if (otp) otp = ($urandom_range(29) != 0); else otp = ($urandom_range(599) == 0);
      if ($urandom_range(299) == 0) ext = EW'($urandom_range(7));
    end

    chk_on = 1'b0;
    summary();
    $finish;
  end

endmodule